// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block sits between a small transmit cell store and the payload mapper of a line transmitter. The write side pushes 53-byte ATM cells byte by byte. A start-of-cell marker opens each cell. The mapper pulls one byte per cycle by asserting a byte enable, and the block always has a byte ready. If no complete user cell is stored when a cell boundary comes up, the block sends an idle cell. Its four header bytes come from a configuration input and its 48 payload bytes carry a programmable fill octet. In this way the rate of user cells is decoupled from the line rate.

For every outgoing cell, user or idle, the header error check byte is computed on the fly over the four header bytes and replaces the fifth byte. The coset can be added to it on request. The 48 payload bytes pass through a self-synchronous scrambler, and the header is sent in the clear. A cell-available flag tells the write side when the store is nearly full. The block also counts the user cells it has sent, and that count can be snapshotted into a holding output.

Top module: `tcp_tx_cell`

## Requirements
- R1: Each `out_en` high at a clock edge emits one byte on `out_data`, valid from that edge. `out_data` holds its value while `out_en` is low. Cells are 53 emitted bytes long. `out_soc` is high for one cycle with the first byte of each cell and low at all other times.
- R2: An idle cell sends `idle_hdr[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` as header bytes 0 to 3. Every one of its payload bytes 5 to 52 carries `idle_fill`, and payload bytes are scrambled as in R4.
- R3: Byte 4 of every cell is the CRC-8 of header bytes 0 to 3. The generator is x^8+x^2+x+1, the initial value is zero and bits are taken MSB first. When `coset_en` is 1, the CRC is XORed with 0x55. Byte 4 of a stored user cell is discarded. For example, the header 00 00 00 01 gives 0x52 with the coset added.
- R4: Payload bytes 5 to 52 are scrambled bit-serially, MSB first, as out = in XOR out(43 bits earlier). The scrambler history runs only over payload bits, is continuous across user and idle cells, and starts at all zeros after reset. Header and check bytes are not scrambled.
- R5: At each cell boundary, the block sends the oldest complete stored cell if there is one, and an idle cell otherwise (`out_idle` = 1 for all 53 bytes). A partially written cell is never started.
- R6: A byte written with `wr_soc` = 1 starts a new cell, and a partial cell is abandoned. Bytes written without `wr_soc` outside a cell are ignored. The 53rd byte completes the cell.
- R7: The store holds 4 cells. A cell whose first byte arrives while 4 cells are stored is dropped as a whole.
- R8: While `fifo_rst` is high, all stored and partial cells are cleared and all writes are ignored. One cycle after it is high, `tca` is 1.
- R9: With `early_tca` = 0, `tca` is 0 exactly when the number of stored complete cells is at least N. N is `depth_sel`, and `depth_sel` = 0 means N = 4.
- R10: With `early_tca` = 1, `tca` is 0 exactly when the stored bytes reach N*53-4. Stored bytes are the complete cells times 53 plus the bytes of the cell being written.
- R11: When the write side stops, the stored cells are sent in order and idle cells follow.
- R12: Each user cell whose last byte is emitted increments a 19-bit count. A `cnt_latch` pulse copies the count into `cnt_hold` at that edge and restarts the count. A cell finishing at that same edge counts as 1 in the new period. `cnt_hold` changes only on `cnt_latch`.
- R13: After reset, `out_data` = 0, `out_soc` = 0, `out_idle` = 0, `tca` = 1 and `cnt_hold` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_rst | input | 1 | Clears the cell store and blocks writes |
| wr_en | input | 1 | Write byte strobe |
| wr_soc | input | 1 | Marks the first byte of a cell |
| wr_data | input | 8 | Write byte |
| tca | output | 1 | Cell-available flag for the write side |
| depth_sel | input | 2 | Fill threshold in cells (0 means 4) |
| early_tca | input | 1 | Drops `tca` 4 bytes before the threshold |
| idle_hdr | input | 32 | Idle cell header, byte 0 in bits 31:24 |
| idle_fill | input | 8 | Idle cell payload octet |
| coset_en | input | 1 | Adds 0x55 to the check byte |
| out_en | input | 1 | Mapper pulls one byte |
| out_data | output | 8 | Emitted byte |
| out_soc | output | 1 | First byte of a cell |
| out_idle | output | 1 | Emitted byte belongs to an idle cell |
| cnt_latch | input | 1 | Snapshot and restart the sent-cell count |
| cnt_hold | output | 19 | Snapshotted sent-cell count |

## Verification
The assertions check the output framing on every cycle. That covers the 53-byte spacing of `out_soc`, the constant idle flag within a cell and `out_data` holding while no byte is pulled. They also check that `tca` recovers after `fifo_rst` and that `cnt_hold` moves only on a latch pulse. The byte values themselves can only be shown by the bench's scenarios, which compare them with a reference model: check bytes with and without the coset, scrambler continuity across mixed cells, cell ordering, and dropping of a fifth cell. The same holds for the fill thresholds in both `tca` modes and a latch that coincides with a cell completion.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
    localparam int HDR_BYTES = 4;
    localparam int HEC_IDX   = 4;
    localparam logic [7:0] HEC_POLY  = 8'h07;
    localparam logic [7:0] HEC_COSET = 8'h55;

    // One byte of CRC-8 (x^8+x^2+x+1), MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] din);
        logic [7:0] c;
        c = crc ^ din;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ HEC_POLY) : (c << 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/tcp_cell_store.sv
module tcp_cell_store #(
    parameter int CELLS      = 4,
    parameter int CELL_BYTES = 53,
    localparam int IDX_W     = $clog2(CELL_BYTES),
    localparam int FILL_W    = $clog2(CELLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic              wr_soc,
    input  logic [7:0]        wr_data,
    input  logic              pop,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_data,
    output logic [FILL_W-1:0] cells,
    output logic [IDX_W-1:0]  part_bytes
);
    localparam int SLOT_W = (CELLS > 1) ? $clog2(CELLS) : 1;
    localparam int DEPTH  = CELLS * CELL_BYTES;
    localparam int ADDR_W = $clog2(DEPTH);

    typedef struct packed {
        logic              in_cell;
        logic [IDX_W-1:0]  wr_idx;
        logic [SLOT_W-1:0] wr_slot;
        logic [SLOT_W-1:0] rd_slot;
        logic [FILL_W-1:0] count;
    } store_t;

    store_t s_d, s_q;
    logic [7:0]        mem [DEPTH];
    logic              mem_we;
    logic [IDX_W-1:0]  widx;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              commit, pop_ok;

    function automatic logic [SLOT_W-1:0] slot_next(input logic [SLOT_W-1:0] s);
        return (s == SLOT_W'(CELLS - 1)) ? '0 : s + 1'b1;
    endfunction

    always_comb begin
        s_d    = s_q;
        mem_we = 1'b0;
        widx   = '0;
        commit = 1'b0;
        pop_ok = pop && (s_q.count != '0);
        if (clr) begin
            s_d = '0;
        end else begin
            if (wr_en) begin
                if (wr_soc) begin
                    if (s_q.count == FILL_W'(CELLS)) begin
                        s_d.in_cell = 1'b0;
                        s_d.wr_idx  = '0;
                    end else begin
                        mem_we      = 1'b1;
                        s_d.in_cell = 1'b1;
                        s_d.wr_idx  = IDX_W'(1);
                    end
                end else if (s_q.in_cell) begin
                    mem_we = 1'b1;
                    widx   = s_q.wr_idx;
                    if (s_q.wr_idx == IDX_W'(CELL_BYTES - 1)) begin
                        commit      = 1'b1;
                        s_d.in_cell = 1'b0;
                        s_d.wr_idx  = '0;
                        s_d.wr_slot = slot_next(s_q.wr_slot);
                    end else begin
                        s_d.wr_idx = s_q.wr_idx + 1'b1;
                    end
                end
            end
            if (pop_ok) s_d.rd_slot = slot_next(s_q.rd_slot);
            s_d.count = s_q.count + FILL_W'(commit) - FILL_W'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign waddr = ADDR_W'(s_q.wr_slot) * ADDR_W'(CELL_BYTES) + ADDR_W'(widx);
    assign raddr = ADDR_W'(s_q.rd_slot) * ADDR_W'(CELL_BYTES) + ADDR_W'(rd_idx);

    always_ff @(posedge clk) begin
        if (mem_we) mem[waddr] <= wr_data;
    end

    assign rd_data    = mem[raddr];
    assign cells      = s_q.count;
    assign part_bytes = s_q.in_cell ? s_q.wr_idx : '0;
endmodule

// File: rtl/tcp_hec_gen.sv
module tcp_hec_gen
    import tcp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       first,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    logic [7:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (adv) crc_d = crc8_step(first ? 8'h00 : crc_q, din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/tcp_payload_scr.sv
module tcp_payload_scr #(
    parameter int LAG = 43
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [LAG-1:0] h_d, h_q;
    logic [LAG-1:0] h_w;
    logic [7:0]     o;

    always_comb begin
        h_w = h_q;
        o   = '0;
        for (int i = 7; i >= 0; i--) begin
            o[i] = din[i] ^ h_w[LAG-1];
            h_w  = {h_w[LAG-2:0], o[i]};
        end
        h_d  = adv ? h_w : h_q;
        dout = o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end
endmodule

// File: rtl/tcp_tx_cell.sv
module tcp_tx_cell
    import tcp_pkg::*;
#(
    parameter int CELLS       = 4,
    parameter int CELL_BYTES  = 53,
    parameter int CNT_W       = 19,
    parameter int EARLY_BYTES = 4,
    parameter int SCR_LAG     = 43
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_rst,
    input  logic             wr_en,
    input  logic             wr_soc,
    input  logic [7:0]       wr_data,
    output logic             tca,
    input  logic [1:0]       depth_sel,
    input  logic             early_tca,
    input  logic [31:0]      idle_hdr,
    input  logic [7:0]       idle_fill,
    input  logic             coset_en,
    input  logic             out_en,
    output logic [7:0]       out_data,
    output logic             out_soc,
    output logic             out_idle,
    input  logic             cnt_latch,
    output logic [CNT_W-1:0] cnt_hold
);
    localparam int IDX_W  = $clog2(CELL_BYTES);
    localparam int FILL_W = $clog2(CELLS + 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             cur_idle;
        logic [7:0]       data;
        logic             soc;
        logic             idle;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
    } tx_t;

    tx_t t_d, t_q;

    logic [7:0]        rd_data, crc, scr_out, raw, hdr_sel, hec;
    logic [FILL_W-1:0] cells;
    logic [IDX_W-1:0]  part_bytes;
    logic              start, is_idle, pop, hec_adv, scr_adv;

    tcp_cell_store #(.CELLS(CELLS), .CELL_BYTES(CELL_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(fifo_rst),
        .wr_en(wr_en), .wr_soc(wr_soc), .wr_data(wr_data),
        .pop(pop), .rd_idx(t_q.idx), .rd_data(rd_data),
        .cells(cells), .part_bytes(part_bytes)
    );

    tcp_hec_gen u_hec (
        .clk(clk), .rst_n(rst_n), .adv(hec_adv), .first(start),
        .din(raw), .crc(crc)
    );

    tcp_payload_scr #(.LAG(SCR_LAG)) u_scr (
        .clk(clk), .rst_n(rst_n), .adv(scr_adv), .din(raw), .dout(scr_out)
    );

    // Byte selection and cell sequencing.
    always_comb begin
        start   = (t_q.idx == '0);
        is_idle = start ? (cells == '0) : t_q.cur_idle;
        hdr_sel = idle_hdr[8*(HDR_BYTES-1-int'(t_q.idx[1:0])) +: 8];
        if (is_idle) raw = (t_q.idx < IDX_W'(HDR_BYTES)) ? hdr_sel : idle_fill;
        else         raw = rd_data;
        hec     = crc ^ (coset_en ? HEC_COSET : 8'h00);
        hec_adv = out_en && (t_q.idx < IDX_W'(HDR_BYTES));
        scr_adv = out_en && (t_q.idx > IDX_W'(HEC_IDX));
        pop     = out_en && !is_idle && (t_q.idx == IDX_W'(CELL_BYTES - 1));

        t_d     = t_q;
        t_d.soc = 1'b0;
        if (out_en) begin
            if (t_q.idx < IDX_W'(HDR_BYTES))      t_d.data = raw;
            else if (t_q.idx == IDX_W'(HEC_IDX))  t_d.data = hec;
            else                                  t_d.data = scr_out;
            t_d.soc      = start;
            t_d.idle     = is_idle;
            t_d.cur_idle = is_idle;
            t_d.idx      = (t_q.idx == IDX_W'(CELL_BYTES - 1)) ? '0 : t_q.idx + 1'b1;
        end

        if (cnt_latch) begin
            t_d.hold = t_q.cnt;
            t_d.cnt  = CNT_W'(pop);
        end else if (pop && (t_q.cnt != '1)) begin
            t_d.cnt  = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // Cell-available flag from the fill level.
    always_comb begin
        int need;
        int fill;
        need = (depth_sel == 2'd0) ? CELLS : int'(depth_sel);
        fill = int'(cells) * CELL_BYTES + int'(part_bytes);
        if (early_tca) tca = (fill < need * CELL_BYTES - EARLY_BYTES);
        else           tca = (int'(cells) < need);
    end

    assign out_data = t_q.data;
    assign out_soc  = t_q.soc;
    assign out_idle = t_q.idle;
    assign cnt_hold = t_q.hold;
endmodule

// File: rtl/tcp_tx_cell_chk.sv
module tcp_tx_cell_chk #(
    parameter int CELL_BYTES = 53,
    parameter int CNT_W      = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_rst,
    input logic             out_en,
    input logic [7:0]       out_data,
    input logic             out_soc,
    input logic             out_idle,
    input logic             tca,
    input logic             cnt_latch,
    input logic [CNT_W-1:0] cnt_hold
);
    localparam int POS_W = $clog2(CELL_BYTES);
    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else if (out_en) pos_q <= (pos_q == POS_W'(CELL_BYTES - 1)) ? '0 : pos_q + 1'b1;
    end

    // R1
    soc_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && pos_q == '0) |=> out_soc);
    // R1
    soc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_en && pos_q == '0) |=> !out_soc);
    // R1
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> $stable(out_data));
    // R5
    idle_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && pos_q != '0) |=> $stable(out_idle));
    // R8
    rst_tca_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst |=> tca);
    // R12
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_latch |=> $stable(cnt_hold));
endmodule

bind tcp_tx_cell tcp_tx_cell_chk #(.CELL_BYTES(CELL_BYTES), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tcp_tx_cell_bench.sv
module tcp_tx_cell_bench;
    localparam int CB = 53;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, fifo_rst, wr_en, wr_soc, early_tca, coset_en, out_en, cnt_latch;
    logic [7:0]  wr_data, idle_fill, out_data;
    logic [1:0]  depth_sel;
    logic [31:0] idle_hdr;
    logic        tca, out_soc, out_idle;
    logic [18:0] cnt_hold;

    tcp_tx_cell u_tcp_tx_cell (.*);

    int checks = 0, fails = 0;

    // Reference model state
    logic [7:0]  mq [4][CB];
    logic [7:0]  pbuf [CB];
    int          mhead = 0, mcount = 0, pidx = 0, tidx = 0;
    bit          pin = 0, tidle = 0;
    logic [42:0] shist = '0;
    int          mcnt = 0;
    logic [18:0] mhold = '0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] crc8(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3);
        logic [7:0] c = 8'h00;
        logic [7:0] bs [4];
        bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
        for (int k = 0; k < 4; k++) begin
            c = c ^ bs[k];
            for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    function automatic bit exp_tca();
        int n = (depth_sel == 0) ? 4 : int'(depth_sel);
        if (early_tca) return (mcount * CB + (pin ? pidx : 0)) < (n * CB - 4);
        return mcount < n;
    endfunction

    task automatic step(bit we, bit ws, logic [7:0] wd, bit oe, bit cl, bit fr);
        logic [7:0] hb [4];
        logic [7:0] raw, ex;
        int pre_count, mc_pre;
        bit popped;
        @(negedge clk);
        wr_en = we; wr_soc = ws; wr_data = wd; out_en = oe; cnt_latch = cl; fifo_rst = fr;
        @(posedge clk);
        #1;
        pre_count = mcount; mc_pre = mcnt; popped = 0;
        if (oe) begin
            if (tidx == 0) tidle = (mcount == 0);
            for (int i = 0; i < 4; i++) hb[i] = tidle ? idle_hdr[31-8*i -: 8] : mq[mhead][i];
            if (tidx < 4) begin
                ex = hb[tidx];
                chk("R2 header byte", out_data, ex);
            end else if (tidx == 4) begin
                ex = crc8(hb[0], hb[1], hb[2], hb[3]) ^ (coset_en ? 8'h55 : 8'h00);
                chk("R3 check byte", out_data, ex);
            end else begin
                raw = tidle ? idle_fill : mq[mhead][tidx];
                for (int b = 7; b >= 0; b--) begin
                    ex[b] = raw[b] ^ shist[42];
                    shist = {shist[41:0], ex[b]};
                end
                chk("R4 payload byte", out_data, ex);
            end
            chk("R1 soc", out_soc, (tidx == 0));
            chk("R5 idle flag", out_idle, tidle);
            if (tidx == CB - 1 && !tidle) begin
                popped = 1;
                mhead = (mhead + 1) % 4;
                mcount--;
                if (mcnt < 19'h7FFFF) mcnt++;
            end
            tidx = (tidx + 1) % CB;
        end
        if (cl) begin
            mhold = 19'(mc_pre);
            mcnt = popped ? 1 : 0;
            chk("R12 hold", cnt_hold, mhold);
        end
        if (fr) begin
            mcount = 0; pin = 0; pidx = 0;
        end else if (we) begin
            if (ws) begin
                if (pre_count == 4) begin pin = 0; pidx = 0; end
                else begin pin = 1; pbuf[0] = wd; pidx = 1; end
            end else if (pin) begin
                pbuf[pidx] = wd;
                if (pidx == CB - 1) begin
                    for (int i = 0; i < CB; i++) mq[(mhead + mcount) % 4][i] = pbuf[i];
                    mcount++; pin = 0; pidx = 0;
                end else pidx++;
            end
        end
        chk(early_tca ? "R10 tca early" : "R9 tca", tca, exp_tca());
    endtask

    task automatic write_cell(int nbytes);
        for (int i = 0; i < nbytes; i++) step(1, i == 0, 8'($urandom), 0, 0, 0);
    endtask

    task automatic stream(int n);
        for (int i = 0; i < n; i++) step(0, 0, 8'h00, 1, 0, 0);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int gpos;
        void'($urandom(32'd20241));
        rst_n = 0; fifo_rst = 0; wr_en = 0; wr_soc = 0; wr_data = 0; out_en = 0; cnt_latch = 0;
        depth_sel = 0; early_tca = 0; idle_hdr = 32'h0000_0001; idle_fill = 8'h6A; coset_en = 1;
        repeat (3) @(posedge clk);
        #1;
        // R13 reset state
        chk("R13 out_data", out_data, 0);
        chk("R13 out_soc", out_soc, 0);
        chk("R13 out_idle", out_idle, 0);
        chk("R13 tca", tca, 1);
        chk("R13 cnt_hold", cnt_hold, 0);
        @(negedge clk); rst_n = 1;

        // R2 R3 idle stream, known check byte 0x52 with coset
        for (int k = 0; k < 2 * CB; k++) begin
            step(0, 0, 8'h00, 1, 0, 0);
            if (k == 4) chk("R3 idle check 0x52", out_data, 8'h52);
        end

        // R9 threshold of 2 cells, then R11 drain
        depth_sel = 2;
        write_cell(CB);
        chk("R9 one cell tca", tca, 1);
        write_cell(CB);
        chk("R9 two cells tca", tca, 0);
        coset_en = 0;
        stream(3 * CB);
        chk("R11 idle after drain", out_idle, 1);

        // R10 early threshold, N = 1
        depth_sel = 1; early_tca = 1;
        write_cell(48);
        chk("R10 48 bytes tca", tca, 1);
        step(1, 0, 8'h3C, 0, 0, 0);
        chk("R10 49 bytes tca", tca, 0);
        for (int i = 0; i < 4; i++) step(1, 0, 8'($urandom), 0, 0, 0);
        stream(CB);

        // R7 fifth cell dropped
        depth_sel = 0; early_tca = 0; coset_en = 1;
        for (int c = 0; c < 5; c++) write_cell(CB);
        chk("R7 full tca", tca, 0);
        for (int c = 0; c < 5; c++) begin
            step(0, 0, 8'h00, 1, 0, 0);
            chk("R7 cell kind", out_idle, (c == 4));
            stream(CB - 1);
        end

        // R8 store clear
        write_cell(CB);
        write_cell(CB);
        for (int i = 0; i < 10; i++) step(1, i == 0, 8'($urandom), 0, 0, 1);
        chk("R8 tca after clear", tca, 1);
        step(0, 0, 8'h00, 1, 0, 0);
        chk("R8 idle after clear", out_idle, 1);
        stream(CB - 1);

        // R12 snapshot, including a completion at the latch edge
        step(0, 0, 8'h00, 0, 1, 0);
        chk("R12 hold count 7", cnt_hold, 7);
        write_cell(CB);
        stream(CB - 1);
        step(0, 0, 8'h00, 1, 1, 0);
        chk("R12 concurrent latch", cnt_hold, 0);
        step(0, 0, 8'h00, 0, 1, 0);
        chk("R12 carried cell", cnt_hold, 1);

        // R6 partial cell abandoned by a new start
        write_cell(20);
        write_cell(CB);
        step(1, 0, 8'h11, 0, 0, 0);
        stream(CB);
        chk("R6 restart cell sent", out_idle, 0);
        stream(CB);

        // Random mixed traffic
        gpos = -1;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            int r;
            bit we, ws, oe, cl;
            if (cyc % 500 == 0) begin
                depth_sel = 2'($urandom);
                early_tca = 1'($urandom);
            end
            r = $urandom % 100;
            we = 0; ws = 0;
            if (r < 60) begin
                we = 1;
                if (gpos < 0 || r < 2) begin ws = 1; gpos = 1; end
                else gpos = (gpos == CB - 1) ? -1 : gpos + 1;
            end else if (r < 63) begin
                we = 1;
            end
            oe = ($urandom % 100) < 55;
            cl = ($urandom % 200) == 0;
            step(we, ws, 8'($urandom), oe, cl, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule